// File: doc/BRIEF.md
# Linked-List DMA Descriptor Loader

This block drives one DMA channel through a chain of transfer descriptors held in memory. Each descriptor starts with a link word and an info word. The link word is the address of the following descriptor. The info word gives the format and flags of that following descriptor. A type-dependent number of parameter words follows these two. The loader reads the words one at a time over a simple word-read master port and writes the parameter words into the channel's working registers. It then hands those registers to a transfer engine and waits for a done pulse. After the pulse it either fetches the next descriptor, stops at the end of the list, or pauses when the link word requests it.

Software sets up the walk through a small register port. That port holds a list control word, the next-descriptor pointer and a completed-descriptor counter. The control word selects list mode and fast start, and it records the pause state. In fast mode the head descriptor is loaded before the first transfer. Otherwise the transfer already sitting in the working registers runs first, and the head descriptor is fetched after it completes. An invalid format code stops the walk and sets a sticky error flag.

Top module: `dma_list_loader`

## Requirements
- R1: After reset all four registers read 0, and `rd_req_o`, `xfer_req_o`, `blk_end_o`, `busy_o` and `err_o` are low.
- R2: Register map, selected by `reg_addr_i`:
  - Address 0 is the control word. Only bits 0, 2, 4, 5, 7, 8 and 10 are kept.
  - Address 1 is the pointer. A write of zero to it is ignored.
  - Address 2 reads the completed count in its low 16 bits. Address 3 reads {err, busy} in bits 1:0.
  - Writes to addresses 2 and 3 are ignored, and every write is ignored while `busy_o` is high.
- R3: A control write that sets bit 8 (list enable) while it was clear does four things. It clears the completed count and the error flag. It loads working slot 2 (element count) with 0x00FFFFFF. It loads slot 3 (frame count) with 0x0000FFFF.
- R4: With control bit 10 (fast) set, a start fetches the head descriptor before any transfer is requested. The head's format comes from control bits 5:4 (1, 2 or 3). Its source-valid flag is bit 2 and its destination-valid flag is bit 0.
- R5: With fast clear, the first start requests a transfer with the current working registers. The head is fetched only after that transfer's done. That first transfer is not counted.
- R6: Descriptor words are read one per request, upward from the pointer with bits 1:0 cleared. Word 0 is the link and word 1 is the info word. Working slot k is presented on `param_o[32k+31:32k]`. The slots are: 0 source, 1 destination, 2 element count, 3 frame count, 4 element index, 5 frame index, 6-11 further control words. Format 1 fills slots 0-11. Format 2 with both address flags fills slots 0-5. Format 3 with both address flags fills slots 0-1.
- R7: Format 2 or 3 without both address flags carries a single address word. That word goes to slot 0 if source is valid, otherwise to slot 1 if destination is valid, otherwise nowhere. For format 2, four words for slots 2-5 follow it.
- R8: Word 0 is written to the pointer register. Word 1's bits 30:29, 24 and 26 are written to control bits 5:4, 2 and 0 respectively. Word 1's bit 28 marks the next descriptor as block-end.
- R9: The completed count rises by one on each done of a descriptor-loaded transfer.
- R10: `blk_end_o` pulses for one cycle, one cycle after the done of a descriptor whose block-end mark was set.
- R11: If bit 0 of the link is set, control bit 7 (pause) is set after that descriptor's done, and the loader goes idle without fetching. Starts are ignored while bit 7 is set. Once software clears bit 7, a start resumes fetching at the link with bits 1:0 cleared.
- R12: A link equal to 0xFFFFFFFC (bit 0 ignored) ends the walk after the current done, with no further reads.
- R13: An info word with bits 30:29 = 00, or a head format of 00 at fetch time, stops the walk before any transfer. In either case `err_o` is set. The flag stays set, and starts are ignored, until a list-enable setup as in R3.
- R14: A start is ignored when list enable is clear or the pointer register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| start_i | input | 1 | Channel start / resume pulse |
| rd_req_o | output | 1 | Descriptor word read request |
| rd_addr_o | output | 32 | Byte address of the requested word |
| rd_valid_i | input | 1 | Read data valid, completes the request |
| rd_data_i | input | 32 | Read data |
| xfer_req_o | output | 1 | Transfer requested, held until done |
| param_o | output | 384 | Working register slots 0-11 |
| xfer_done_i | input | 1 | Transfer engine done pulse |
| blk_end_o | output | 1 | Block-end notification pulse |
| busy_o | output | 1 | Channel active |
| err_o | output | 1 | Sticky format error |

## Verification
The hardest state to reach is a resume after a pause in normal start mode. At that point the loader already owns the list, a pointer with its low bit set sits in the register, and the control word holds the next format and flags taken from memory. The bench gets there with a chain whose head link carries the pause bit. It checks that a start is ignored while the pause bit is set. It then clears the bit with a read-modify-write value and starts again, expecting fetching to resume at the masked link. The error path is reached through a memory descriptor whose info word has a zero format. A head format of zero is tested as well.

// File: rtl/dma_list_pkg.sv
package dma_list_pkg;
  localparam int WORD_W     = 32;
  localparam int NSLOT      = 12;
  localparam int MID_SLOTS  = 6;
  localparam int ADDR_SLOTS = 2;
  localparam int SLOT_W     = $clog2(NSLOT);
  localparam int IDX_W      = $clog2(NSLOT + 3);

  localparam logic [WORD_W-1:0] LINK_END  = 32'hFFFF_FFFC;
  localparam logic [WORD_W-1:0] ECNT_INIT = 32'h00FF_FFFF;
  localparam logic [WORD_W-1:0] FCNT_INIT = 32'h0000_FFFF;

  // control word bit positions
  localparam int CB_DST   = 0;
  localparam int CB_SRC   = 2;
  localparam int CB_TLO   = 4;
  localparam int CB_PAUSE = 7;
  localparam int CB_LIST  = 8;
  localparam int CB_FAST  = 10;
  localparam logic [WORD_W-1:0] CTRL_MASK = 32'h0000_05B5;

  // info word bit positions
  localparam int NB_SRC = 24;
  localparam int NB_DST = 26;
  localparam int NB_BLK = 28;
  localparam int NB_TLO = 29;

  localparam int SL_SRC  = 0;
  localparam int SL_DST  = 1;
  localparam int SL_ECNT = 2;
  localparam int SL_FCNT = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_XFER} ld_state_e;
endpackage

// File: rtl/dma_list_wordmap.sv
module dma_list_wordmap
  import dma_list_pkg::*;
(
  input  logic [1:0]        dtype_i,
  input  logic              src_v_i,
  input  logic              dst_v_i,
  input  logic [SLOT_W-1:0] pay_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              slot_we_o,
  output logic              last_o
);
  logic              single;
  logic [SLOT_W-1:0] npay;

  always_comb begin
    single = (dtype_i != 2'd1) && !(src_v_i && dst_v_i);
    case (dtype_i)
      2'd1:    npay = SLOT_W'(NSLOT);
      2'd2:    npay = single ? SLOT_W'(MID_SLOTS - 1) : SLOT_W'(MID_SLOTS);
      2'd3:    npay = single ? SLOT_W'(ADDR_SLOTS - 1) : SLOT_W'(ADDR_SLOTS);
      default: npay = SLOT_W'(1);
    endcase
    slot_o    = pay_i;
    slot_we_o = 1'b1;
    if (single) begin
      if (pay_i == '0) begin
        slot_o    = src_v_i ? SLOT_W'(SL_SRC) : SLOT_W'(SL_DST);
        slot_we_o = src_v_i | dst_v_i;
      end else begin
        slot_o = pay_i + SLOT_W'(1);
      end
    end
    last_o = (pay_i == npay - SLOT_W'(1));
  end
endmodule

// File: rtl/dma_list_params.sv
module dma_list_params
  import dma_list_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    init_i,
  input  logic                    we_i,
  input  logic [SLOT_W-1:0]       slot_i,
  input  logic [WORD_W-1:0]       wdata_i,
  output logic [NSLOT*WORD_W-1:0] param_o
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [WORD_W-1:0] q;
    if (g == SL_ECNT || g == SL_FCNT) begin : g_init
      localparam logic [WORD_W-1:0] INIT_V = (g == SL_ECNT) ? ECNT_INIT : FCNT_INIT;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              q <= '0;
        else if (init_i)                          q <= INIT_V;
        else if (we_i && slot_i == SLOT_W'(g))    q <= wdata_i;
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              q <= '0;
        else if (we_i && slot_i == SLOT_W'(g))    q <= wdata_i;
      end
    end
    assign param_o[g*WORD_W +: WORD_W] = q;
  end
endmodule

// File: rtl/dma_list_loader.sv
module dma_list_loader
  import dma_list_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    reg_we_i,
  input  logic [1:0]              reg_addr_i,
  input  logic [WORD_W-1:0]       reg_wdata_i,
  output logic [WORD_W-1:0]       reg_rdata_o,
  input  logic                    start_i,
  output logic                    rd_req_o,
  output logic [WORD_W-1:0]       rd_addr_o,
  input  logic                    rd_valid_i,
  input  logic [WORD_W-1:0]       rd_data_i,
  output logic                    xfer_req_o,
  output logic [NSLOT*WORD_W-1:0] param_o,
  input  logic                    xfer_done_i,
  output logic                    blk_end_o,
  output logic                    busy_o,
  output logic                    err_o
);
  ld_state_e         state_q;
  logic [WORD_W-1:0] ctrl_q, ptr_q, base_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              err_q, in_list_q, desc_xfer_q, blk_q;
  logic              cur_src_q, cur_dst_q, cur_blk_q, pend_blk_q;
  logic [1:0]        cur_type_q;
  logic [IDX_W-1:0]  widx_q;

  logic              idle, reg_wr, list_init, accept, launch, xfer_fin, at_end;
  logic [SLOT_W-1:0] pay_idx, map_slot;
  logic              map_we, map_last, pw_we;
  logic [1:0]        nxt_type;

  assign idle      = (state_q == ST_IDLE);
  assign reg_wr    = reg_we_i && idle;
  assign list_init = reg_wr && reg_addr_i == 2'd0 && reg_wdata_i[CB_LIST] && !ctrl_q[CB_LIST];
  assign xfer_fin  = (state_q == ST_XFER) && xfer_done_i;
  assign at_end    = {ptr_q[WORD_W-1:1], 1'b0} == LINK_END;
  assign accept    = start_i && !reg_we_i && idle && ctrl_q[CB_LIST] && !ctrl_q[CB_PAUSE]
                     && !err_q && ptr_q != '0;
  assign launch    = (accept && (in_list_q || ctrl_q[CB_FAST]))
                   || (xfer_fin && (!desc_xfer_q || (!at_end && !ptr_q[0])));
  assign pay_idx   = SLOT_W'(widx_q - IDX_W'(2));
  assign nxt_type  = rd_data_i[NB_TLO +: 2];
  assign pw_we     = (state_q == ST_FETCH) && rd_valid_i && widx_q >= IDX_W'(2) && map_we;

  dma_list_wordmap u_map (
    .dtype_i   (cur_type_q),
    .src_v_i   (cur_src_q),
    .dst_v_i   (cur_dst_q),
    .pay_i     (pay_idx),
    .slot_o    (map_slot),
    .slot_we_o (map_we),
    .last_o    (map_last)
  );

  dma_list_params u_params (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .init_i  (list_init),
    .we_i    (pw_we),
    .slot_i  (map_slot),
    .wdata_i (rd_data_i),
    .param_o (param_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      ctrl_q      <= '0;
      ptr_q       <= '0;
      base_q      <= '0;
      cnt_q       <= '0;
      err_q       <= 1'b0;
      in_list_q   <= 1'b0;
      desc_xfer_q <= 1'b0;
      blk_q       <= 1'b0;
      cur_src_q   <= 1'b0;
      cur_dst_q   <= 1'b0;
      cur_blk_q   <= 1'b0;
      pend_blk_q  <= 1'b0;
      cur_type_q  <= '0;
      widx_q      <= '0;
    end else begin
      blk_q <= xfer_fin && desc_xfer_q && cur_blk_q;
      if (reg_wr && reg_addr_i == 2'd0) ctrl_q <= reg_wdata_i & CTRL_MASK;
      if (reg_wr && reg_addr_i == 2'd1 && reg_wdata_i != '0) ptr_q <= reg_wdata_i;
      if (list_init) begin
        cnt_q      <= '0;
        err_q      <= 1'b0;
        in_list_q  <= 1'b0;
        pend_blk_q <= 1'b0;
      end
      if (xfer_fin && desc_xfer_q) cnt_q <= cnt_q + CNT_W'(1);

      case (state_q)
        ST_IDLE: if (accept && !launch) begin
          state_q     <= ST_XFER;       // programmed transfer runs before the head
          desc_xfer_q <= 1'b0;
          in_list_q   <= 1'b1;
        end
        ST_FETCH: if (rd_valid_i) begin
          widx_q <= widx_q + IDX_W'(1);
          if (widx_q == IDX_W'(0)) begin
            ptr_q <= rd_data_i;
          end else if (widx_q == IDX_W'(1)) begin
            ctrl_q[CB_TLO +: 2] <= nxt_type;
            ctrl_q[CB_SRC]      <= rd_data_i[NB_SRC];
            ctrl_q[CB_DST]      <= rd_data_i[NB_DST];
            pend_blk_q          <= rd_data_i[NB_BLK];
            if (nxt_type == 2'd0) begin
              err_q     <= 1'b1;
              in_list_q <= 1'b0;
              state_q   <= ST_IDLE;
            end
          end else if (map_last) begin
            state_q     <= ST_XFER;
            desc_xfer_q <= 1'b1;
          end
        end
        ST_XFER: if (xfer_done_i && desc_xfer_q) begin
          if (at_end) begin
            state_q   <= ST_IDLE;
            in_list_q <= 1'b0;
          end else if (ptr_q[0]) begin
            state_q          <= ST_IDLE;
            ctrl_q[CB_PAUSE] <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase

      if (launch) begin
        if (ctrl_q[CB_TLO +: 2] == 2'd0) begin
          err_q     <= 1'b1;
          in_list_q <= 1'b0;
          state_q   <= ST_IDLE;
        end else begin
          state_q    <= ST_FETCH;
          widx_q     <= '0;
          base_q     <= {ptr_q[WORD_W-1:2], 2'b00};
          cur_type_q <= ctrl_q[CB_TLO +: 2];
          cur_src_q  <= ctrl_q[CB_SRC];
          cur_dst_q  <= ctrl_q[CB_DST];
          cur_blk_q  <= pend_blk_q;
          in_list_q  <= 1'b1;
        end
      end
    end
  end

  assign busy_o     = !idle;
  assign err_o      = err_q;
  assign blk_end_o  = blk_q;
  assign rd_req_o   = (state_q == ST_FETCH);
  assign rd_addr_o  = base_q + (WORD_W'(widx_q) << 2);
  assign xfer_req_o = (state_q == ST_XFER);

  always_comb begin
    case (reg_addr_i)
      2'd0:    reg_rdata_o = ctrl_q;
      2'd1:    reg_rdata_o = ptr_q;
      2'd2:    reg_rdata_o = WORD_W'(cnt_q);
      default: reg_rdata_o = {{(WORD_W-2){1'b0}}, err_q, busy_o};
    endcase
  end

  assert_zero_ptr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && !busy_o && reg_addr_i == 2'd1 && reg_wdata_i == '0 |=> ptr_q == $past(ptr_q));
  assert_busy_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && reg_we_i && reg_addr_i == 2'd0
    |=> ctrl_q[CB_LIST] == $past(ctrl_q[CB_LIST]) && ctrl_q[CB_FAST] == $past(ctrl_q[CB_FAST]));
  assert_hold_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_addr_o));
  assert_cnt_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != $past(cnt_q) |-> cnt_q == '0 || (cnt_q == $past(cnt_q) + CNT_W'(1) && $past(xfer_done_i)));
  assert_blk_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_end_o |=> !blk_end_o);
  assert_pause_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_q[CB_PAUSE]) |-> !busy_o);
  assert_err_sticky_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q && !list_init |=> err_q);
endmodule

// File: tb/dma_list_loader_bench.sv
`timescale 1ns/1ps
module dma_list_loader_bench;
  localparam int NS = 12;
  localparam int PWID = NS * 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_we = 1'b0;
  logic [1:0]      reg_addr = 2'd0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            start = 1'b0;
  logic            rd_req, rd_valid;
  logic [31:0]     rd_addr, rd_data;
  logic            xfer_req, xfer_done = 1'b0;
  logic [PWID-1:0] param;
  logic            blk_end, busy, err;

  logic [31:0]     mem [64];
  logic            tog = 1'b0;
  logic            stall_en = 1'b0;
  int              total = 0, bad = 0;
  int              na = 0, nx = 0, nblk = 0, blk_at = 0, hold = 0;
  logic [31:0]     alog [64];
  logic [PWID-1:0] xlog [8];
  int              xna [8];
  bit              finished = 0;

  always #10 clk = ~clk;
  always @(posedge clk) tog <= ~tog;

  assign rd_valid = rd_req && (tog || !stall_en);
  assign rd_data  = mem[rd_addr[7:2]];

  dma_list_loader u_dma_list_loader (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .start_i(start),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .xfer_req_o(xfer_req), .param_o(param), .xfer_done_i(xfer_done),
    .blk_end_o(blk_end), .busy_o(busy), .err_o(err)
  );

  // transfer engine model and observers
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_req && rd_valid && na < 64) begin alog[na] = rd_addr; na++; end
      if (blk_end) begin nblk++; blk_at = nx; end
      if (xfer_done) begin xfer_done = 1'b0; hold = 0; end
      else if (xfer_req) begin
        hold++;
        if (hold == 3) begin
          xfer_done = 1'b1;
          if (nx < 8) begin xlog[nx] = param; xna[nx] = na; end
          nx++;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic clr_logs();
    na = 0; nx = 0; nblk = 0; blk_at = 0;
  endtask

  function automatic logic [31:0] sl(input logic [PWID-1:0] p, input int k);
    return p[k*32 +: 32];
  endfunction

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // {write addr, write data, read addr, expected}
  localparam logic [67:0] VEC [7] = '{
    {2'd1, 32'h0000_0040, 2'd1, 32'h0000_0040},
    {2'd1, 32'h0000_0000, 2'd1, 32'h0000_0040},
    {2'd0, 32'hFFFF_FFFF, 2'd0, 32'h0000_05B5},
    {2'd2, 32'h0000_1234, 2'd2, 32'h0000_0000},
    {2'd0, 32'h0000_0000, 2'd0, 32'h0000_0000},
    {2'd3, 32'hFFFF_FFFF, 2'd3, 32'h0000_0000},
    {2'd1, 32'h0000_0007, 2'd1, 32'h0000_0007}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    int mis;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[16] = 32'h0000_0080; mem[17] = 32'h5400_0000;
    for (int k = 0; k < 12; k++) mem[18+k] = 32'hA000_0000 + k;
    mem[32] = 32'h0000_00C0; mem[33] = 32'h6500_0000;
    for (int k = 0; k < 5; k++) mem[34+k] = 32'hB000_0000 + k;
    mem[48] = 32'hFFFF_FFFC; mem[49] = 32'h2000_0000;
    mem[50] = 32'hC000_0000; mem[51] = 32'hC000_0001;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(2'(a), v); chk("R1", v, 32'h0); end
    chk("R1", {27'd0, rd_req, xfer_req, blk_end, busy, err}, 32'h0);

    // R14 start ignored with zero pointer
    wr(2'd0, 32'h515);
    clr_logs();
    pulse_start();
    repeat (5) @(negedge clk);
    chk("R14", {31'd0, busy}, 32'd0);
    chk("R14", na, 0);
    wr(2'd0, 32'h0);

    // R2 register table
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][67:66], VEC[i][65:34]);
      rd(VEC[i][33:32], v);
      chk("R2", v, VEC[i][31:0]);
    end
    chk("R3", sl(param, 2), 32'h00FF_FFFF);
    chk("R3", sl(param, 3), 32'h0000_FFFF);

    // Scenario A: fast start, three formats, end of list
    stall_en = 1'b1;
    wr(2'd1, 32'h40); wr(2'd0, 32'h0); wr(2'd0, 32'h515);
    clr_logs();
    pulse_start();
    wr(2'd1, 32'h99);           // ignored while busy (R2)
    wait_idle();
    chk("R4", xna[0], 14);
    chk("R6", na, 25);
    mis = 0;
    for (int k = 0; k < 14; k++) if (alog[k] !== 32'h40 + 4*k) mis++;
    for (int k = 0; k < 7; k++)  if (alog[14+k] !== 32'h80 + 4*k) mis++;
    for (int k = 0; k < 4; k++)  if (alog[21+k] !== 32'hC0 + 4*k) mis++;
    chk("R6", mis, 0);
    mis = 0;
    for (int k = 0; k < 12; k++) if (sl(xlog[0], k) !== 32'hA000_0000 + k) mis++;
    chk("R6", mis, 0);
    chk("R7", sl(xlog[1], 0), 32'hA000_0000);
    chk("R7", sl(xlog[1], 1), 32'hB000_0000);
    mis = 0;
    for (int k = 2; k < 6; k++) if (sl(xlog[1], k) !== 32'hB000_0000 + k - 1) mis++;
    for (int k = 6; k < 12; k++) if (sl(xlog[1], k) !== 32'hA000_0000 + k) mis++;
    chk("R7", mis, 0);
    chk("R6", sl(xlog[2], 0), 32'hC000_0000);
    chk("R6", sl(xlog[2], 1), 32'hC000_0001);
    chk("R12", nx, 3);
    rd(2'd2, v); chk("R9", v, 32'd3);
    chk("R10", nblk, 1);
    chk("R10", blk_at, 2);
    rd(2'd0, v); chk("R8", v, 32'h510);
    rd(2'd1, v); chk("R12", v, 32'hFFFF_FFFC);
    repeat (10) @(negedge clk);
    chk("R12", na, 25);

    // Scenario B: normal start, pause and resume
    stall_en = 1'b0;
    mem[16] = 32'h0000_0081;
    wr(2'd0, 32'h0); wr(2'd1, 32'h40); wr(2'd0, 32'h115);
    clr_logs();
    pulse_start();
    wait_idle();
    chk("R5", xna[0], 0);
    chk("R5", sl(xlog[0], 2), 32'h00FF_FFFF);
    chk("R5", sl(xlog[0], 3), 32'h0000_FFFF);
    chk("R5", nx, 2);
    rd(2'd2, v); chk("R5", v, 32'd1);
    rd(2'd0, v); chk("R11", v, 32'h1A1);
    rd(2'd1, v); chk("R8", v, 32'h81);
    chk("R11", na, 14);
    pulse_start();
    repeat (5) @(negedge clk);
    chk("R11", {31'd0, busy}, 32'd0);
    chk("R11", na, 14);
    wr(2'd0, 32'h121);
    pulse_start();
    wait_idle();
    chk("R11", alog[14], 32'h80);
    rd(2'd2, v); chk("R9", v, 32'd3);
    chk("R11", nx, 4);
    chk("R10", nblk, 1);

    // Scenario C: zero format in info word, then in head
    mem[8] = 32'h40; mem[9] = 32'h0; mem[10] = 32'hD000_0000;
    wr(2'd0, 32'h0); wr(2'd1, 32'h20); wr(2'd0, 32'h534);
    clr_logs();
    pulse_start();
    wait_idle();
    chk("R13", {31'd0, err}, 32'd1);
    chk("R13", na, 2);
    chk("R13", nx, 0);
    rd(2'd3, v); chk("R13", v, 32'h2);
    pulse_start();
    repeat (5) @(negedge clk);
    chk("R13", na, 2);
    wr(2'd0, 32'h0); wr(2'd0, 32'h500);
    chk("R13", {31'd0, err}, 32'd0);
    pulse_start();
    repeat (5) @(negedge clk);
    chk("R13", {31'd0, err}, 32'd1);
    chk("R13", na, 2);

    finished = 1;
    summary();
  end
endmodule